// File: doc/BRIEF.md
# Raw-Encoding Float Estimate Unit

This block produces rough Binary32 estimates of a reciprocal, a quotient and a square root without any divide or root datapath. Each operand's sign, exponent and fraction bits are read as one unsigned 32-bit integer, and the estimate comes from a single add, subtract or one-bit shift against a fixed constant. Nothing is unpacked or normalised. The result is an ordinary Binary32 word. It suits work where accuracy matters little, such as colour arithmetic or coarse distance tests. It can also serve as the seed for a few later Newton-Raphson steps done elsewhere.

A request is one operation code, one or two operands and a valid strobe. The block registers the result and its valid flag and presents them one clock later. Unary operations look only at operand A. If an operand that the operation uses has an exponent field of all ones (infinity or NaN), the computed value is replaced by a canonical quiet NaN. A fourth code passes operand A through untouched. All integer arithmetic wraps modulo 2^32.

Top module: `bta_unit`

## Requirements
- R1: With op code 2'b00 (reciprocal), the result is 0x7F000000 minus in_a, as a 32-bit integer subtraction that wraps modulo 2^32.
- R2: With op code 2'b01 (divide), the result is 0x3F800000 plus in_a minus in_b, in 32-bit integer arithmetic that wraps modulo 2^32.
- R3: With op code 2'b10 (square root), the result is 0x1FC00000 plus in_a shifted right logically by one bit, so the sign bit of in_a moves into bit 30.
- R4: With op code 2'b11 (pass), the result equals in_a bit for bit, whatever its exponent.
- R5: For op codes 00, 01 and 10, if any operand the operation uses has bits 30:23 all ones, the result is 0x7FC00000 instead of the computed value.
- R6: For op codes 00, 10 and 11, in_b has no effect on the result, even when its exponent bits are all ones.
- R7: out_valid and out_data reflect an accepted request exactly one clock edge after in_valid is sampled high. out_valid is low after any edge at which in_valid was low.
- R8: out_data keeps its last value across cycles in which in_valid is low.
- R9: A synchronous active-high rst clears out_valid at the next clock edge, and out_data reads zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_op | input | 2 | Operation code: 00 reciprocal, 01 divide, 10 square root, 11 pass |
| in_a | input | 32 | Operand A (value, dividend or radicand) |
| in_b | input | 32 | Operand B (divisor, used by divide only) |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_data | output | 32 | Registered Binary32 estimate |

## Verification
The NaN guard and the wrapping integer arithmetic act in the same cycle. A divide whose raw arithmetic overflows or goes below zero can also carry a special operand, and the guard must take priority over the wrapped sum. The bench drives such a request, with an all-ones exponent in the divisor only, and expects 0x7FC00000. A second request with finite operands that wrap must give the modulo-2^32 value. Reset can also coincide with a valid request. The bench asserts both together and expects out_valid low and out_data zero after that edge.

// File: rtl/bta_pkg.sv
package bta_pkg;
  typedef enum logic [1:0] {
    OP_RECIP = 2'b00,
    OP_DIV   = 2'b01,
    OP_SQRT  = 2'b10,
    OP_PASS  = 2'b11
  } bta_op_e;

  localparam int unsigned OPERANDS = 2;
endpackage

// File: rtl/bta_special_detect.sv
module bta_special_detect #(
  parameter int W      = 32,
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [W-1:0] operand,
  output logic         exp_max
);
  localparam int EXP_LO = FRAC_W;
  localparam int EXP_HI = FRAC_W + EXP_W - 1;

  always_comb begin
    exp_max = &operand[EXP_HI:EXP_LO];
  end
endmodule

// File: rtl/bta_approx_core.sv
module bta_approx_core
  import bta_pkg::*;
#(
  parameter int           W       = 32,
  parameter int           EXP_W   = 8,
  parameter int           FRAC_W  = 23,
  parameter logic [W-1:0] RECIP_K = 32'h7F00_0000,
  parameter logic [W-1:0] DIV_K   = 32'h3F80_0000,
  parameter logic [W-1:0] SQRT_K  = 32'h1FC0_0000
) (
  input  bta_op_e      op,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         a_special,
  input  logic         b_special,
  output logic [W-1:0] result
);
  localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic [W-1:0] recip_v;
  logic [W-1:0] div_v;
  logic [W-1:0] sqrt_v;
  logic         guard;

  // Each estimate is one integer operation on the raw encoding.
  always_comb begin
    recip_v = RECIP_K - opa;
    div_v   = DIV_K + opa - opb;
    sqrt_v  = SQRT_K + (opa >> 1);
  end

  // Only the operands an operation uses can trigger the NaN guard.
  always_comb begin
    unique case (op)
      OP_RECIP: guard = a_special;
      OP_DIV:   guard = a_special | b_special;
      OP_SQRT:  guard = a_special;
      default:  guard = 1'b0;
    endcase
  end

  always_comb begin
    if (guard) begin
      result = QNAN;
    end else begin
      unique case (op)
        OP_RECIP: result = recip_v;
        OP_DIV:   result = div_v;
        OP_SQRT:  result = sqrt_v;
        default:  result = opa;
      endcase
    end
  end
endmodule

// File: rtl/bta_unit.sv
module bta_unit
  import bta_pkg::*;
#(
  parameter int W      = 32,
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [1:0]   in_op,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  output logic         out_valid,
  output logic [W-1:0] out_data
);
  localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
  localparam int EXP_LO = FRAC_W;
  localparam int EXP_HI = FRAC_W + EXP_W - 1;

  logic [W-1:0]        ops     [OPERANDS];
  logic [OPERANDS-1:0] special;
  logic [W-1:0]        next_data;
  bta_op_e             op_e;

  assign ops[0] = in_a;
  assign ops[1] = in_b;
  assign op_e   = bta_op_e'(in_op);

  for (genvar i = 0; i < OPERANDS; i++) begin : g_detect
    bta_special_detect #(
      .W(W), .EXP_W(EXP_W), .FRAC_W(FRAC_W)
    ) u_det (
      .operand(ops[i]),
      .exp_max(special[i])
    );
  end

  bta_approx_core #(
    .W(W), .EXP_W(EXP_W), .FRAC_W(FRAC_W)
  ) u_core (
    .op       (op_e),
    .opa      (in_a),
    .opb      (in_b),
    .a_special(special[0]),
    .b_special(special[1]),
    .result   (next_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data <= next_data;
      end
    end
  end

  assert_latency_R7: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_data));

  assert_pass_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 2'b11) |=> out_data == $past(in_a));

  assert_nan_a_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op != 2'b11 && (&in_a[EXP_HI:EXP_LO])) |=> out_data == QNAN);

  assert_nan_b_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 2'b01 && (&in_b[EXP_HI:EXP_LO])) |=> out_data == QNAN);
endmodule

// File: tb/bta_unit_test.sv
module bta_unit_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [1:0]  in_op;
  logic [31:0] in_a;
  logic [31:0] in_b;
  logic        out_valid;
  logic [31:0] out_data;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  bta_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_data(out_data)
  );

  function automatic logic [31:0] model(input logic [1:0] op, input logic [31:0] a,
                                        input logic [31:0] b);
    logic sa, sb;
    sa = (a[30:23] == 8'hFF);
    sb = (b[30:23] == 8'hFF);
    case (op)
      2'b00:   return sa ? 32'h7FC0_0000 : 32'h7F00_0000 - a;
      2'b01:   return (sa || sb) ? 32'h7FC0_0000 : 32'h3F80_0000 + a - b;
      2'b10:   return sa ? 32'h7FC0_0000 : 32'h1FC0_0000 + {1'b0, a[31:1]};
      default: return a;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_op(input string req, input logic [1:0] op,
                        input logic [31:0] a, input logic [31:0] b);
    issue(op, a, b);
    check(req, {31'b0, out_valid}, 32'd1);
    check(req, out_data, model(op, a, b));
  endtask

  task automatic test_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1; in_op = 2'b11; in_a = 32'h1234_5678; in_b = '0;
    @(negedge clk);
    rst = 1'b0; in_valid = 1'b0;
    check("R9 valid", {31'b0, out_valid}, 32'd0);
    check("R9 data", out_data, 32'd0);
  endtask

  task automatic test_recip();
    run_op("R1 one", 2'b00, 32'h3F80_0000, 32'h0);
    run_op("R1 two", 2'b00, 32'h4000_0000, 32'h0);
    run_op("R1 wrap", 2'b00, 32'hC000_0000, 32'h0);
    check("R1 half", out_data, 32'hBF00_0000);
  endtask

  task automatic test_divide();
    run_op("R2 4/2", 2'b01, 32'h4080_0000, 32'h4000_0000);
    check("R2 4/2 value", out_data, 32'h4000_0000);
    run_op("R2 wrap low", 2'b01, 32'h0000_0000, 32'h7F00_0000);
    run_op("R2 wrap high", 2'b01, 32'hFF00_0000, 32'h0000_0001);
  endtask

  task automatic test_sqrt();
    run_op("R3 four", 2'b10, 32'h4080_0000, 32'h0);
    check("R3 four value", out_data, 32'h4000_0000);
    run_op("R3 one", 2'b10, 32'h3F80_0000, 32'h0);
    run_op("R3 negative", 2'b10, 32'hC080_0000, 32'h0);
  endtask

  task automatic test_pass();
    run_op("R4 plain", 2'b11, 32'hDEAD_BEEF, 32'h0);
    run_op("R4 nan", 2'b11, 32'h7F80_0001, 32'h7F80_0000);
    check("R4 nan value", out_data, 32'h7F80_0001);
  endtask

  task automatic test_guard();
    run_op("R5 recip inf", 2'b00, 32'h7F80_0000, 32'h0);
    check("R5 recip value", out_data, 32'h7FC0_0000);
    run_op("R5 sqrt nan", 2'b10, 32'hFFC0_0001, 32'h0);
    run_op("R5 div a", 2'b01, 32'hFF80_0000, 32'h3F80_0000);
    run_op("R5 div b", 2'b01, 32'h0000_0000, 32'h7F80_0000);
    check("R5 div b value", out_data, 32'h7FC0_0000);
  endtask

  task automatic test_ignore_b();
    run_op("R6 recip", 2'b00, 32'h4000_0000, 32'h7F80_0000);
    check("R6 recip value", out_data, 32'h3F00_0000);
    run_op("R6 sqrt", 2'b10, 32'h4080_0000, 32'hFFFF_FFFF);
    check("R6 sqrt value", out_data, 32'h4000_0000);
    run_op("R6 pass", 2'b11, 32'h0000_0042, 32'h7FC0_0000);
  endtask

  task automatic test_timing_hold();
    run_op("R7 seed", 2'b00, 32'h3F80_0000, 32'h0);
    @(negedge clk);
    in_op = 2'b11; in_a = 32'hAAAA_5555;
    @(negedge clk);
    check("R7 idle valid", {31'b0, out_valid}, 32'd0);
    check("R8 hold", out_data, 32'h3F80_0000);
    @(negedge clk);
    in_valid = 1'b1; in_op = 2'b10; in_a = 32'h4080_0000;
    @(negedge clk);
    in_op = 2'b11; in_a = 32'h0000_0007;
    check("R7 back to back 1", out_data, 32'h4000_0000);
    @(negedge clk);
    in_valid = 1'b0;
    check("R7 back to back 2", out_data, 32'h0000_0007);
    check("R7 valid kept", {31'b0, out_valid}, 32'd1);
    @(negedge clk);
    check("R7 valid drop", {31'b0, out_valid}, 32'd0);
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_op = 2'b00; in_a = '0; in_b = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    test_reset();
    test_recip();
    test_divide();
    test_sqrt();
    test_pass();
    test_guard();
    test_ignore_b();
    test_timing_hold();
    test_reset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule